// File: doc/BRIEF.md
# Multiframe Q/S Maintenance Channel Controller

This block runs the maintenance side of a basic-rate S/T-interface multiframe on the network side. A neighbouring framer handles the serial bits. It supplies a frame-start strobe, a multiframe-start strobe, a 1 µs tick and the Q bits it has extracted. The block keeps a frame counter and a microsecond counter from those strobes. At fixed points in each multiframe it raises events, captures the received Q nibble and hands the framer a parallel word of transmit S-subchannel bits.

A processor uses a small register port with a combinational read path. Through it the processor enables multiframing, masks the two interrupt sources and loads five S-subchannel registers. It can also read the captured Q value, the clear-on-read status register and a global summary bit. The S registers feed a shadow word. The shadow word is loaded only a few microseconds before each multiframe boundary. The start-of-multiframe event follows the boundary by a fixed delay. Between these two points the processor has a guaranteed window in which to write the next S values.

Top module: `mf_qs_ctrl`

## Requirements
- R1: While enabled, the start-of-multiframe flag (status bit 0) is set once per multiframe. It takes effect on the clock edge that ends the cycle lying SOM_DELAY_US ticks after the multiframe-start strobe. The strobe cycle itself counts as time 0.
- R2: On that same edge, q_rx_i is captured into the Q register. The Q register reads at address 4 in bits [Q_W-1:0].
- R3: The Q-change flag (status bit 1) is set on a capture whose new value differs from the value held before.
- R4: Status is read at address 1 with bit 0 = start-of-multiframe and bit 1 = Q-change. A read with reg_rd_i clears both flags. A flag whose event occurs in the same cycle as the read stays set.
- R5: The mask register is at address 2. Bit 0 masks start-of-multiframe and bit 1 masks Q-change. A 0 enables the source, and the register resets to 2'b11.
- R6: irq_o is the OR of the pending flags whose mask bit is 0. The same value reads at address 3, bit 0.
- R7: The S registers sit at addresses 5 to 9 with S_W bits each. Register k drives s_tx_o[k*S_W +: S_W] once it is copied. The copy happens on the edge that ends the cycle lying LATCH_LEAD_US ticks before the next multiframe start. A write in that same cycle is carried only at the following copy.
- R8: The enable bit is bit 0 at address 0. While it is 0, no flag is set, the Q register is not updated and s_tx_o is all zeros.
- R9: After reset, the enable bit, the flags, the Q register, the S registers, s_tx_o and irq_o are all 0, and the mask is 2'b11.
- R10: A frame-start strobe clears the microsecond count, and a multiframe-start strobe also clears the frame count. No event occurs before the first multiframe-start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| frame_start_i | input | 1 | Frame-start strobe from the framer |
| mf_start_i | input | 1 | Multiframe-start strobe from the framer |
| q_rx_i | input | Q_W | Received Q bits of the current multiframe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status when at address 1) |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt, active high |
| s_tx_o | output | NUM_S*S_W | Transmit S shadow word for the framer |

## Verification
The bench builds the block with 8 µs frames, 4 frames per multiframe, a 3 µs event delay and a 2 µs latch lead, and ticks every cycle. One multiframe is then 32 cycles, so twelve multiframes can be checked cycle by cycle. With this setup the sweep moves the status read and the S writes across positions that include the event cycle and the latch cycle. It also covers the cycles next to them, every mask value, the repeated and changed Q patterns, and a disable and re-enable in the middle of the run.

// File: rtl/mf_qs_pkg.sv
package mf_qs_pkg;
  typedef struct packed {
    logic qsc;
    logic som;
  } irq_flags_t;

  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_STAT   = 1;
  localparam int unsigned ADDR_MASK   = 2;
  localparam int unsigned ADDR_GLOB   = 3;
  localparam int unsigned ADDR_QRX    = 4;
  localparam int unsigned ADDR_S_BASE = 5;
endpackage

// File: rtl/mf_qs_timer.sv
module mf_qs_timer #(
  parameter int unsigned US_PER_FRAME  = 250,
  parameter int unsigned FRAMES_PER_MF = 20,
  parameter int unsigned SOM_DELAY_US  = 27,
  parameter int unsigned LATCH_LEAD_US = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic frame_start_i,
  input  logic mf_start_i,
  output logic som_ev_o,
  output logic latch_ev_o
);
  localparam int unsigned US_W = (US_PER_FRAME > 1) ? $clog2(US_PER_FRAME) : 1;
  localparam int unsigned FR_W = (FRAMES_PER_MF > 1) ? $clog2(FRAMES_PER_MF) : 1;
  localparam logic [US_W-1:0] US_LAST  = US_W'(US_PER_FRAME - 1);
  localparam logic [FR_W-1:0] FR_LAST  = FR_W'(FRAMES_PER_MF - 1);
  localparam logic [US_W-1:0] SOM_AT   = US_W'(SOM_DELAY_US - 1);
  localparam logic [US_W-1:0] LATCH_AT = US_W'(US_PER_FRAME - LATCH_LEAD_US - 1);

  logic [US_W-1:0] us_q;
  logic [FR_W-1:0] fr_q;
  logic            locked_q;
  logic            strobe;

  assign strobe = frame_start_i | mf_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      us_q     <= '0;
      fr_q     <= '0;
      locked_q <= 1'b0;
    end else begin
      if (strobe)                        us_q <= '0;
      else if (tick_i && us_q != US_LAST) us_q <= us_q + 1'b1;

      if (mf_start_i)                            fr_q <= '0;
      else if (frame_start_i && fr_q != FR_LAST) fr_q <= fr_q + 1'b1;

      if (mf_start_i) locked_q <= 1'b1;
    end
  end

  // events fire on the tick that completes the target microsecond
  assign som_ev_o   = en_i && locked_q && !strobe && tick_i &&
                      fr_q == '0 && us_q == SOM_AT;
  assign latch_ev_o = en_i && locked_q && !strobe && tick_i &&
                      fr_q == FR_LAST && us_q == LATCH_AT;
endmodule

// File: rtl/mf_qs_irq.sv
module mf_qs_irq (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   som_ev_i,
  input  logic                   qsc_ev_i,
  input  logic                   rd_clr_i,
  input  logic [1:0]             mask_i,
  output mf_qs_pkg::irq_flags_t  flags_o,
  output logic                   irq_o
);
  mf_qs_pkg::irq_flags_t flags_q;

  // event beats clear when both land in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else begin
      if (som_ev_i)      flags_q.som <= 1'b1;
      else if (rd_clr_i) flags_q.som <= 1'b0;
      if (qsc_ev_i)      flags_q.qsc <= 1'b1;
      else if (rd_clr_i) flags_q.qsc <= 1'b0;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & ~mask_i);
endmodule

// File: rtl/mf_qs_regs.sv
module mf_qs_regs #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned Q_W    = 4,
  parameter int unsigned S_W    = 4,
  parameter int unsigned NUM_S  = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  input  logic                    som_ev_i,
  input  logic                    latch_ev_i,
  input  logic [Q_W-1:0]          q_rx_i,
  input  mf_qs_pkg::irq_flags_t   flags_i,
  input  logic                    irq_i,
  output logic                    en_o,
  output logic [1:0]              mask_o,
  output logic                    rd_clr_o,
  output logic                    qsc_ev_o,
  output logic [NUM_S*S_W-1:0]    s_tx_o
);
  import mf_qs_pkg::*;

  logic                 en_q;
  logic [1:0]           mask_q;
  logic [Q_W-1:0]       q_q;
  logic [S_W-1:0]       s_reg_q [NUM_S];
  logic [NUM_S*S_W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mask_q <= 2'b11;
      q_q    <= '0;
    end else begin
      if (wr_i && addr_i == ADDR_W'(ADDR_CTRL)) en_q   <= wdata_i[0];
      if (wr_i && addr_i == ADDR_W'(ADDR_MASK)) mask_q <= wdata_i[1:0];
      if (som_ev_i)                              q_q    <= q_rx_i;
    end
  end

  // latch reads the pre-write register value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_S; k++) s_reg_q[k] <= '0;
      shadow_q <= '0;
    end else begin
      for (int k = 0; k < NUM_S; k++) begin
        if (wr_i && addr_i == ADDR_W'(ADDR_S_BASE + k)) s_reg_q[k] <= wdata_i[S_W-1:0];
        if (!en_q)           shadow_q[k*S_W +: S_W] <= '0;
        else if (latch_ev_i) shadow_q[k*S_W +: S_W] <= s_reg_q[k];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(ADDR_CTRL): rdata_o = DATA_W'(en_q);
      ADDR_W'(ADDR_STAT): rdata_o = DATA_W'(flags_i);
      ADDR_W'(ADDR_MASK): rdata_o = DATA_W'(mask_q);
      ADDR_W'(ADDR_GLOB): rdata_o = DATA_W'(irq_i);
      ADDR_W'(ADDR_QRX):  rdata_o = DATA_W'(q_q);
      default: begin
        for (int k = 0; k < NUM_S; k++)
          if (addr_i == ADDR_W'(ADDR_S_BASE + k)) rdata_o = DATA_W'(s_reg_q[k]);
      end
    endcase
  end

  assign en_o     = en_q;
  assign mask_o   = mask_q;
  assign rd_clr_o = rd_i && addr_i == ADDR_W'(ADDR_STAT);
  assign qsc_ev_o = som_ev_i && (q_rx_i != q_q);
  assign s_tx_o   = shadow_q;
endmodule

// File: rtl/mf_qs_ctrl.sv
module mf_qs_ctrl #(
  parameter int unsigned US_PER_FRAME  = 250,
  parameter int unsigned FRAMES_PER_MF = 20,
  parameter int unsigned SOM_DELAY_US  = 27,
  parameter int unsigned LATCH_LEAD_US = 3,
  parameter int unsigned Q_W           = 4,
  parameter int unsigned S_W           = 4,
  parameter int unsigned NUM_S         = 5,
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned DATA_W        = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_us_i,
  input  logic                 frame_start_i,
  input  logic                 mf_start_i,
  input  logic [Q_W-1:0]       q_rx_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 irq_o,
  output logic [NUM_S*S_W-1:0] s_tx_o
);
  logic                  en;
  logic [1:0]            mask;
  logic                  som_ev;
  logic                  latch_ev;
  logic                  qsc_ev;
  logic                  rd_clr;
  mf_qs_pkg::irq_flags_t flags;

  mf_qs_timer #(
    .US_PER_FRAME (US_PER_FRAME),
    .FRAMES_PER_MF(FRAMES_PER_MF),
    .SOM_DELAY_US (SOM_DELAY_US),
    .LATCH_LEAD_US(LATCH_LEAD_US)
  ) i_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .tick_i       (tick_us_i),
    .frame_start_i(frame_start_i),
    .mf_start_i   (mf_start_i),
    .som_ev_o     (som_ev),
    .latch_ev_o   (latch_ev)
  );

  mf_qs_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .Q_W   (Q_W),
    .S_W   (S_W),
    .NUM_S (NUM_S)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr_i),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .som_ev_i  (som_ev),
    .latch_ev_i(latch_ev),
    .q_rx_i    (q_rx_i),
    .flags_i   (flags),
    .irq_i     (irq_o),
    .en_o      (en),
    .mask_o    (mask),
    .rd_clr_o  (rd_clr),
    .qsc_ev_o  (qsc_ev),
    .s_tx_o    (s_tx_o)
  );

  mf_qs_irq i_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .som_ev_i(som_ev),
    .qsc_ev_i(qsc_ev),
    .rd_clr_i(rd_clr),
    .mask_i  (mask),
    .flags_o (flags),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/mf_qs_ctrl_chk.sv
module mf_qs_ctrl_chk #(
  parameter int unsigned NUM_S = 5,
  parameter int unsigned S_W   = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  en,
  input logic [1:0]            mask,
  input logic                  som_ev,
  input logic                  latch_ev,
  input logic                  qsc_ev,
  input logic                  rd_clr,
  input mf_qs_pkg::irq_flags_t flags,
  input logic                  irq_o,
  input logic [NUM_S*S_W-1:0]  s_tx_o
);
  p_som_src_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags.som) |-> $past(som_ev));

  p_som_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    som_ev |=> !som_ev);

  p_qsc_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags.qsc) |-> $past(qsc_ev));

  p_rd_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && !som_ev && !qsc_ev) |=> (flags == '0));

  p_unmasked_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags.som && !mask[0]) || (flags.qsc && !mask[1])) |-> irq_o);

  p_shadow_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !latch_ev) |=> $stable(s_tx_o));

  p_off_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (s_tx_o == '0));

  p_off_no_ev_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (!som_ev && !latch_ev));
endmodule

bind mf_qs_ctrl mf_qs_ctrl_chk #(.NUM_S(NUM_S), .S_W(S_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en      (en),
  .mask    (mask),
  .som_ev  (som_ev),
  .latch_ev(latch_ev),
  .qsc_ev  (qsc_ev),
  .rd_clr  (rd_clr),
  .flags   (flags),
  .irq_o   (irq_o),
  .s_tx_o  (s_tx_o)
);

// File: tb/test_mf_qs_ctrl.sv
module test_mf_qs_ctrl;
  localparam int US   = 8;
  localparam int FR   = 4;
  localparam int SOM  = 3;
  localparam int LEAD = 2;
  localparam int QW   = 4;
  localparam int SW   = 4;
  localparam int NS   = 5;
  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int MF   = US * FR;
  localparam int NMF  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0, fstart = 1'b0, mstart = 1'b0;
  logic [QW-1:0] q_rx = '0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  logic [NS*SW-1:0] s_tx;

  int n_vec = 0;
  int n_bad = 0;

  logic          e_en = 1'b0, e_som = 1'b0, e_qsc = 1'b0;
  logic [1:0]    e_mask = 2'b11;
  logic [QW-1:0] e_q = '0;
  logic [SW-1:0] e_s [NS];
  logic [NS*SW-1:0] e_shadow = '0;

  always #10 clk = ~clk;

  mf_qs_ctrl #(
    .US_PER_FRAME(US), .FRAMES_PER_MF(FR), .SOM_DELAY_US(SOM),
    .LATCH_LEAD_US(LEAD), .Q_W(QW), .S_W(SW), .NUM_S(NS),
    .ADDR_W(AW), .DATA_W(DW)
  ) i_mf_qs_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick),
    .frame_start_i(fstart), .mf_start_i(mstart), .q_rx_i(q_rx),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .s_tx_o(s_tx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic e_irq();
    return (e_som & ~e_mask[0]) | (e_qsc & ~e_mask[1]);
  endfunction

  task automatic idle_op();
    wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic wr_cycle(input int a, input int d);
    @(negedge clk);
    idle_op();
    addr = AW'(a); wdata = DW'(d); wr = 1'b1;
    @(negedge clk);
    idle_op();
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [QW-1:0] q_prev;
    for (int k = 0; k < NS; k++) e_s[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick  = 1'b1;

    // R9: reset state
    @(negedge clk);
    chk("R9 irq", 32'(irq), 0);
    chk("R9 shadow", 32'(s_tx), 0);
    addr = 0; #1 chk("R9 ctrl", 32'(rdata), 0);
    addr = 1; #1 chk("R9 status", 32'(rdata), 0);
    addr = 2; #1 chk("R9 mask", 32'(rdata), 3);
    addr = 4; #1 chk("R9 qreg", 32'(rdata), 0);
    for (int k = 0; k < NS; k++) begin
      addr = AW'(5 + k); #1 chk("R9 sreg", 32'(rdata), 0);
    end

    // R10: enabled and unmasked, frame strobes only, no multiframe strobe
    wr_cycle(0, 1);
    wr_cycle(2, 0);
    for (int c = 0; c < 5 * US; c++) begin
      @(negedge clk);
      fstart = (c % US) == 0;
      addr = 1; #1
      chk("R10 status", 32'(rdata), 0);
      chk("R10 irq", 32'(irq), 0);
    end
    fstart = 1'b0;
    wr_cycle(0, 0);
    wr_cycle(2, 3);

    q_prev = '0;
    for (int mf = 0; mf < NMF; mf++) begin
      logic [QW-1:0] q_cur;
      int rd_t;
      q_cur = (mf % 3 == 2) ? q_prev : QW'(mf * 5 + 3);
      q_prev = q_cur;
      rd_t = (mf * 7) % MF;
      for (int t = 0; t < MF; t++) begin
        logic ev_som, ev_lat, rdc;
        @(negedge clk);
        chk("R1 R5 R6 irq", 32'(irq), 32'(e_irq()));
        chk("R7 R8 shadow", 32'(s_tx), 32'(e_shadow));
        idle_op();
        mstart = (t == 0);
        fstart = (t % US) == 0;
        q_rx   = q_cur;
        rdc    = 1'b0;
        if (t == 0 && mf == 1) begin
          addr = 0; wdata = 1; wr = 1'b1;
        end else if (t == 0 && mf == 2) begin
          addr = 2; wdata = 0; wr = 1'b1;
        end else if (t == 0 && mf >= 8) begin
          addr = 2; wdata = DW'(mf & 3); wr = 1'b1;
        end else if (t == 1 && mf == 10) begin
          addr = 0; wdata = 0; wr = 1'b1;
        end else if (t == 1 && mf == 11) begin
          addr = 0; wdata = 1; wr = 1'b1;
        end else if (t == rd_t) begin
          addr = 1; rd = 1'b1; rdc = 1'b1;
          #1 chk("R1 R3 R4 status", 32'(rdata), 32'({e_qsc, e_som}));
        end else if (t == SOM + 2) begin
          addr = 3;
          #1 chk("R6 global", 32'(rdata), 32'(e_irq()));
        end else if (t == MF - 1) begin
          addr = 4;
          #1 chk("R2 qreg", 32'(rdata), 32'(e_q));
        end else begin
          for (int k = 0; k < NS; k++)
            if (t == 26 + k + (mf % 2)) begin
              addr = AW'(5 + k); wdata = DW'((mf * 3 + k * 7 + 1) & 15); wr = 1'b1;
            end
        end
        // expected state after the coming edge
        ev_som = e_en && (t == SOM);
        ev_lat = e_en && (t == MF - LEAD);
        if (!e_en) e_shadow = '0;
        else if (ev_lat)
          for (int k = 0; k < NS; k++) e_shadow[k*SW +: SW] = e_s[k];
        if (ev_som) begin
          e_som = 1'b1;
          if (q_cur != e_q) e_qsc = 1'b1;
          else if (rdc) e_qsc = 1'b0;
          e_q = q_cur;
        end else if (rdc) begin
          e_som = 1'b0;
          e_qsc = 1'b0;
        end
        if (wr) begin
          if (addr == 0) e_en = wdata[0];
          if (addr == 2) e_mask = wdata[1:0];
          for (int k = 0; k < NS; k++)
            if (int'(addr) == 5 + k) e_s[k] = wdata[SW-1:0];
        end
      end
    end
    @(negedge clk);
    idle_op();
    mstart = 1'b0; fstart = 1'b0;
    chk("R7 final shadow", 32'(s_tx), 32'(e_shadow));
    for (int k = 0; k < NS; k++) begin
      addr = AW'(5 + k); #1 chk("R7 sreg readback", 32'(rdata), 32'(e_s[k]));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule